// File: doc/BRIEF.md
# Selectable-Source CRC Engine

This block folds a stream of data beats into a running checksum and reports the final value when the stream ends. A single control write chooses three things: where the data comes from, which polynomial is used, and how wide each beat is. The data can come from a register-style I/O port or from one of several DMA channel streams. After a valid configuration is accepted, the engine is busy and the whole control setting is frozen. It stays frozen until the selected source signals the end of the data, or until the enable input is dropped.

Each source delivers beats over a valid/ready pair. A beat transfers on any rising edge where both valid and ready are high. Ready is high only for the one source selected by the active configuration, and only while the engine is busy and enabled. A source that is not selected sees ready low and must hold its beat. The engine never stalls the selected source, so its ready stays high for the whole run. Every beat of 1, 2 or 4 bytes is absorbed in a single cycle. The bytes are taken least-significant first.

Two checksums are available. The 16-bit one uses polynomial 0x1021, shifts most-significant bit first, starts at 0xFFFF and has no final inversion. The 32-bit one uses reflected polynomial 0xEDB88320, starts at 0xFFFFFFFF and is inverted when the result is captured.

Top module: `crc_engine`

## Requirements
- R1: After reset, busy is 0, the source readback is 0x00 (no action), the result is 0, done is 0, and every ready output is 0.
- R2: A control write accepted while enabled and idle starts a run, and busy reads 1 from the following cycle, when all three fields are valid. The valid fields are: source 0x01 (I/O port) or 0x20+n (DMA channel n, n below the channel count); polynomial 0 (16-bit) or 1 (32-bit); beat size 0 (1 byte), 1 (2 bytes) or 2 (4 bytes).
- R3: A control write is treated as no action and busy stays 0 if it carries any of these: source 0x00, source 0x02–0x1F, a source at or above 0x20 plus the channel count, polynomial 2 or 3, or beat size 3.
- R4: While busy, control writes are ignored. The source readback keeps its value, and the polynomial and beat size of the run in progress do not change.
- R5: A source's ready is 1 only if that source is selected, the engine is busy and enable is 1. At most one ready is high at a time, and a beat is consumed only on valid and ready.
- R6: With polynomial 0 the result is the 16-bit checksum described above, zero-extended to 32 bits. For the bytes "123456789" it is 0x000029B1.
- R7: With polynomial 1 the result is the inverted 32-bit checksum described above. For the bytes "123456789" it is 0xCBF43926.
- R8: A beat contributes only its low 1, 2 or 4 bytes, as set by the beat size, least-significant byte first. Bits above the beat width have no effect.
- R9: When the source is the I/O port, a completion pulse ends the run. In the next cycle busy is 0, the result holds the final checksum, and done is high for one cycle.
- R10: When the source is a DMA channel, only that channel's end pulse ends the run, with the same timing as R9. End pulses from other channels are ignored.
- R11: Driving enable to 0 clears busy in the next cycle. It leaves the result unchanged and does not raise done.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Engine enable; low aborts a run |
| cfg_wr | input | 1 | Control write strobe |
| cfg_src | input | 6 | Source code to write |
| cfg_poly | input | 2 | Polynomial code to write |
| cfg_beat | input | 2 | Beat size code to write |
| cfg_src_rd | output | 6 | Stored source code |
| io_valid | input | 1 | I/O port beat valid |
| io_ready | output | 1 | I/O port beat ready |
| io_data | input | 32 | I/O port beat data |
| io_done | input | 1 | I/O completion pulse |
| dma_valid | input | NCH | Per-channel beat valid |
| dma_ready | output | NCH | Per-channel beat ready |
| dma_data | input | 32*NCH | Per-channel beat data, channel n at bits 32n+31:32n |
| dma_end | input | NCH | Per-channel end-of-data pulse |
| busy | output | 1 | Run in progress; control locked |
| result | output | 32 | Final checksum of the last completed run |
| done | output | 1 | One-cycle pulse when result is updated |

## Verification
A control write is captured at the rising edge where it is presented. Busy and the source readback change right after that edge. A beat is absorbed at the edge where valid and ready are both high. A completion pulse updates result, busy and done at its own edge. Done then falls one edge later. Ready is a combinational function of the stored state, so it is valid in the same cycle. The bench drives every input at a falling edge and reads each result at the next falling edge, half a period after the register that produces it. The check on done falling is made one further falling edge later.

// File: rtl/crc_pkg.sv
package crc_pkg;
  localparam int unsigned WORD_W   = 32;
  localparam int unsigned SRC_W    = 6;
  localparam logic [15:0] P16      = 16'h1021;
  localparam logic [31:0] P32_REFL = 32'hEDB88320;
  localparam logic [SRC_W-1:0] SRC_NONE = 6'h00;
  localparam logic [SRC_W-1:0] SRC_IO   = 6'h01;
  localparam logic [SRC_W-1:0] SRC_CH0  = 6'h20;

  typedef enum logic [1:0] {POLY_16 = 2'd0, POLY_32 = 2'd1} poly_e;
  typedef enum logic [1:0] {BEAT_1B = 2'd0, BEAT_2B = 2'd1, BEAT_4B = 2'd2} beat_e;

  // One byte through the forward 16-bit register (MSB first).
  function automatic logic [31:0] step16(input logic [31:0] c, input logic [7:0] d);
    logic [15:0] r;
    r = c[15:0] ^ {d, 8'h00};
    for (int k = 0; k < 8; k++) r = r[15] ? ((r << 1) ^ P16) : (r << 1);
    return {16'h0000, r};
  endfunction

  // One byte through the reflected 32-bit register (LSB first).
  function automatic logic [31:0] step32(input logic [31:0] c, input logic [7:0] d);
    logic [31:0] r;
    r = c ^ {24'h000000, d};
    for (int k = 0; k < 8; k++) r = r[0] ? ((r >> 1) ^ P32_REFL) : (r >> 1);
    return r;
  endfunction
endpackage

// File: rtl/crc_ctrl.sv
module crc_ctrl
  import crc_pkg::*;
#(
  parameter int unsigned NCH = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  logic             wr,
  input  logic [SRC_W-1:0] src_in,
  input  logic [1:0]       poly_in,
  input  logic [1:0]       beat_in,
  input  logic             finish,
  output logic             busy,
  output logic             start,
  output logic [SRC_W-1:0] src_q,
  output logic [1:0]       poly_q,
  output logic [1:0]       beat_q
);
  localparam logic [SRC_W:0] CH_END = (SRC_W+1)'(32 + NCH);

  logic src_ok, poly_ok, beat_ok, cfg_ok;

  always_comb begin
    src_ok  = (src_in == SRC_IO) ||
              (src_in >= SRC_CH0 && {1'b0, src_in} < CH_END);
    poly_ok = (poly_in == POLY_16) || (poly_in == POLY_32);
    beat_ok = (beat_in != 2'd3);
    cfg_ok  = src_ok && poly_ok && beat_ok;
    start   = wr && enable && !busy && cfg_ok;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy   <= 1'b0;
      src_q  <= SRC_NONE;
      poly_q <= 2'd0;
      beat_q <= 2'd0;
    end else if (!enable) begin
      busy <= 1'b0;
    end else if (busy) begin
      if (finish) busy <= 1'b0;
    end else if (wr) begin
      src_q  <= src_in;
      poly_q <= poly_in;
      beat_q <= beat_in;
      busy   <= cfg_ok;
    end
  end

  // R4: configuration frozen across consecutive busy cycles
  a_r4_cfg_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> ($stable(src_q) && $stable(poly_q) && $stable(beat_q)));

  // R3: reserved codes never start a run
  a_r3_reserved_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && !busy && (src_in == SRC_NONE || poly_in[1] || beat_in == 2'd3)) |=> !busy);
endmodule

// File: rtl/crc_src_sel.sv
module crc_src_sel
  import crc_pkg::*;
#(
  parameter int unsigned NCH = 12
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  active,
  input  logic [SRC_W-1:0]      src_q,
  input  logic                  io_valid,
  input  logic [WORD_W-1:0]     io_data,
  input  logic                  io_done,
  input  logic [NCH-1:0]        dma_valid,
  input  logic [NCH*WORD_W-1:0] dma_data,
  input  logic [NCH-1:0]        dma_end,
  output logic                  io_ready,
  output logic [NCH-1:0]        dma_ready,
  output logic                  fire,
  output logic [WORD_W-1:0]     beat_data,
  output logic                  finish
);
  logic [NCH-1:0] ch_sel;

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    localparam logic [SRC_W-1:0] CODE = SRC_W'(32 + i);
    assign ch_sel[i]    = active && (src_q == CODE);
    assign dma_ready[i] = ch_sel[i];
  end

  assign io_ready = active && (src_q == SRC_IO);

  always_comb begin
    fire      = io_ready && io_valid;
    finish    = io_ready && io_done;
    beat_data = io_data;
    for (int i = 0; i < NCH; i++) begin
      if (ch_sel[i]) begin
        fire      = dma_valid[i];
        finish    = dma_end[i];
        beat_data = dma_data[i*WORD_W +: WORD_W];
      end
    end
  end

  // R5: at most one source is offered ready
  a_r5_ready_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({io_ready, dma_ready}));

  // R5: no ready while the engine is not running
  a_r5_idle_no_ready: assert property (@(posedge clk) disable iff (!rst_n)
    !active |-> (!io_ready && dma_ready == '0));
endmodule

// File: rtl/crc_fold.sv
module crc_fold
  import crc_pkg::*;
(
  input  logic [WORD_W-1:0] crc_in,
  input  logic [WORD_W-1:0] data,
  input  logic [1:0]        poly,
  input  logic [1:0]        beat,
  output logic [WORD_W-1:0] crc_out
);
  localparam int unsigned NB = WORD_W / 8;

  logic [2:0]        nbytes;
  logic [WORD_W-1:0] stage [NB+1];

  always_comb begin
    unique case (beat)
      BEAT_2B: nbytes = 3'd2;
      BEAT_4B: nbytes = 3'd4;
      default: nbytes = 3'd1;
    endcase
  end

  assign stage[0] = crc_in;

  for (genvar b = 0; b < NB; b++) begin : g_byte
    logic [WORD_W-1:0] nxt;
    assign nxt = (poly == POLY_32) ? step32(stage[b], data[8*b +: 8])
                                   : step16(stage[b], data[8*b +: 8]);
    assign stage[b+1] = (3'(b) < nbytes) ? nxt : stage[b];
  end

  assign crc_out = stage[NB];
endmodule

// File: rtl/crc_engine.sv
module crc_engine
  import crc_pkg::*;
#(
  parameter int unsigned NCH = 12
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  enable,
  input  logic                  cfg_wr,
  input  logic [5:0]            cfg_src,
  input  logic [1:0]            cfg_poly,
  input  logic [1:0]            cfg_beat,
  output logic [5:0]            cfg_src_rd,
  input  logic                  io_valid,
  output logic                  io_ready,
  input  logic [31:0]           io_data,
  input  logic                  io_done,
  input  logic [NCH-1:0]        dma_valid,
  output logic [NCH-1:0]        dma_ready,
  input  logic [NCH*32-1:0]     dma_data,
  input  logic [NCH-1:0]        dma_end,
  output logic                  busy,
  output logic [31:0]           result,
  output logic                  done
);
  logic              start, fire, finish, active;
  logic [SRC_W-1:0]  src_q;
  logic [1:0]        poly_q, beat_q;
  logic [WORD_W-1:0] beat_data, crc_q, fold_out, crc_next, final_val;

  assign active = busy && enable;

  crc_ctrl #(.NCH(NCH)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .enable(enable), .wr(cfg_wr),
    .src_in(cfg_src), .poly_in(cfg_poly), .beat_in(cfg_beat),
    .finish(finish), .busy(busy), .start(start),
    .src_q(src_q), .poly_q(poly_q), .beat_q(beat_q)
  );

  crc_src_sel #(.NCH(NCH)) u_sel (
    .clk(clk), .rst_n(rst_n), .active(active), .src_q(src_q),
    .io_valid(io_valid), .io_data(io_data), .io_done(io_done),
    .dma_valid(dma_valid), .dma_data(dma_data), .dma_end(dma_end),
    .io_ready(io_ready), .dma_ready(dma_ready),
    .fire(fire), .beat_data(beat_data), .finish(finish)
  );

  crc_fold u_fold (
    .crc_in(crc_q), .data(beat_data), .poly(poly_q), .beat(beat_q),
    .crc_out(fold_out)
  );

  assign crc_next  = fire ? fold_out : crc_q;
  assign final_val = (poly_q == POLY_32) ? ~crc_next : {16'h0000, crc_next[15:0]};
  assign cfg_src_rd = src_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      crc_q  <= '0;
      result <= '0;
      done   <= 1'b0;
    end else begin
      done <= 1'b0;
      if (start) begin
        crc_q <= (cfg_poly == POLY_32) ? 32'hFFFF_FFFF : 32'h0000_FFFF;
      end else if (active) begin
        crc_q <= crc_next;
        if (finish) begin
          result <= final_val;
          done   <= 1'b1;
        end
      end
    end
  end

  // R9: done never coincides with a run still in progress
  a_r9_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  // R11: dropping enable ends any run without a completion
  a_r11_disable_abort: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> (!busy && !done && $stable(result)));
endmodule

// File: tb/tb_crc_engine.sv
module tb_crc_engine;
  localparam int NCH = 12;

  logic clk = 1'b0, rst_n = 1'b0, enable = 1'b0;
  logic cfg_wr = 1'b0;
  logic [5:0] cfg_src = '0, cfg_src_rd;
  logic [1:0] cfg_poly = '0, cfg_beat = '0;
  logic io_valid = 1'b0, io_ready, io_done = 1'b0;
  logic [31:0] io_data = '0, result;
  logic [NCH-1:0] dma_valid = '0, dma_ready, dma_end = '0;
  logic [NCH*32-1:0] dma_data = '0;
  logic busy, done;

  int vectors = 0, errors = 0;
  byte unsigned digits [9] = '{8'h31,8'h32,8'h33,8'h34,8'h35,8'h36,8'h37,8'h38,8'h39};

  always #10 clk = ~clk;

  crc_engine #(.NCH(NCH)) dut (.*);

  function automatic logic [15:0] m16(input logic [15:0] c, input logic [7:0] d);
    logic [15:0] r = c;
    for (int k = 7; k >= 0; k--) begin
      logic fb = r[15] ^ d[k];
      r = {r[14:0], 1'b0};
      if (fb) r = r ^ 16'h1021;
    end
    return r;
  endfunction

  function automatic logic [31:0] m32(input logic [31:0] c, input logic [7:0] d);
    logic [31:0] r = c;
    for (int k = 0; k < 8; k++) begin
      logic fb = r[0] ^ d[k];
      r = {1'b0, r[31:1]};
      if (fb) r = r ^ 32'hEDB88320;
    end
    return r;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic cfg(input logic [5:0] s, input logic [1:0] p, input logic [1:0] b);
    @(negedge clk);
    cfg_wr = 1'b1; cfg_src = s; cfg_poly = p; cfg_beat = b;
    @(negedge clk);
    cfg_wr = 1'b0;
  endtask

  task automatic io_beat(input logic [31:0] d);
    @(negedge clk);
    io_valid = 1'b1; io_data = d;
    @(negedge clk);
    io_valid = 1'b0; io_data = 32'hDEAD_BEEF;
  endtask

  task automatic io_finish();
    @(negedge clk);
    io_done = 1'b1;
    @(negedge clk);
    io_done = 1'b0;
  endtask

  task automatic t_reset();
    chk("R1 busy", busy, 0);
    chk("R1 src", cfg_src_rd, 0);
    chk("R1 result", result, 0);
    chk("R1 done", done, 0);
    chk("R1 ready", {io_ready, dma_ready}, 0);
  endtask

  task automatic t_crc16_bytes();
    cfg(6'h01, 2'd0, 2'd0);
    chk("R2 busy after start", busy, 1);
    chk("R5 io ready", io_ready, 1);
    foreach (digits[i]) io_beat({24'hA5C3F0, digits[i]});   // R8 junk above byte
    io_finish();
    chk("R6 crc16 check value", result, 32'h0000_29B1);
    chk("R9 busy cleared", busy, 0);
    chk("R9 done pulse", done, 1);
    @(negedge clk);
    chk("R9 done one cycle", done, 0);
  endtask

  task automatic t_crc32_bytes();
    cfg(6'h01, 2'd1, 2'd0);
    foreach (digits[i]) io_beat({24'h5A5A5A, digits[i]});
    io_finish();
    chk("R7 crc32 check value", result, 32'hCBF4_3926);
  endtask

  task automatic t_word32();
    logic [31:0] m = 32'hFFFF_FFFF;
    logic [31:0] w [3] = '{32'h3433_3231, 32'h3837_3635, 32'h0BAD_F00D};
    cfg(6'h01, 2'd1, 2'd2);
    foreach (w[i]) begin
      io_beat(w[i]);
      for (int b = 0; b < 4; b++) m = m32(m, w[i][8*b +: 8]);
    end
    io_finish();
    chk("R8 word beats crc32", result, ~m);
  endtask

  task automatic t_hword16();
    logic [15:0] m = 16'hFFFF;
    logic [15:0] h [4] = '{16'h3231, 16'h3433, 16'h3635, 16'h3837};
    cfg(6'h01, 2'd0, 2'd1);
    foreach (h[i]) begin
      io_beat({16'hFACE, h[i]});
      m = m16(m, h[i][7:0]);
      m = m16(m, h[i][15:8]);
    end
    io_finish();
    chk("R8 hword beats crc16", result, {16'h0, m});
  endtask

  task automatic t_reserved();
    logic [5:0] s [5] = '{6'h00, 6'h05, 6'h2C, 6'h01, 6'h01};
    logic [1:0] p [5] = '{2'd0, 2'd0, 2'd1, 2'd2, 2'd0};
    logic [1:0] b [5] = '{2'd0, 2'd0, 2'd0, 2'd0, 2'd3};
    for (int i = 0; i < 5; i++) begin
      cfg(s[i], p[i], b[i]);
      chk("R3 reserved stays idle", busy, 0);
      chk("R3 no ready", {io_ready, dma_ready}, 0);
    end
  endtask

  task automatic t_lock();
    cfg(6'h01, 2'd0, 2'd0);
    cfg(6'h25, 2'd1, 2'd2);
    chk("R4 source readback held", cfg_src_rd, 6'h01);
    chk("R4 still busy", busy, 1);
    chk("R5 locked ready stays io", {io_ready, dma_ready}, {1'b1, 12'h000});
    foreach (digits[i]) io_beat({24'h0, digits[i]});
    io_finish();
    chk("R4 polynomial unchanged", result, 32'h0000_29B1);
  endtask

  task automatic t_dma();
    logic [31:0] m = 32'hFFFF_FFFF;
    cfg(6'h25, 2'd1, 2'd2);
    chk("R2 dma busy", busy, 1);
    chk("R5 only ch5 ready", {io_ready, dma_ready}, 13'h0020);
    @(negedge clk);
    dma_valid = 12'h028;
    dma_data[5*32 +: 32] = 32'h3433_3231;
    dma_data[3*32 +: 32] = 32'hFFFF_FFFF;
    io_valid = 1'b1;
    @(negedge clk);
    dma_valid = '0; io_valid = 1'b0;
    for (int b = 0; b < 4; b++) m = m32(m, 8'h31 + 8'(b));
    @(negedge clk);
    dma_end = 12'h008;
    @(negedge clk);
    dma_end = '0;
    chk("R10 other channel end ignored", busy, 1);
    @(negedge clk);
    dma_end = 12'h020;
    @(negedge clk);
    dma_end = '0;
    chk("R10 dma end clears busy", busy, 0);
    chk("R10 dma result", result, ~m);
    chk("R10 dma done", done, 1);
  endtask

  task automatic t_disable();
    logic [31:0] prev;
    prev = result;
    cfg(6'h01, 2'd1, 2'd0);
    io_beat(32'h0000_0031);
    @(negedge clk);
    enable = 1'b0;
    @(negedge clk);
    chk("R11 busy cleared", busy, 0);
    chk("R11 result unchanged", result, prev);
    chk("R11 no done", done, 0);
    chk("R5 no ready when disabled", {io_ready, dma_ready}, 0);
    enable = 1'b1;
  endtask

  initial begin
    #(20 * 100000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1; enable = 1'b1;
    @(negedge clk);
    t_crc16_bytes();
    t_crc32_bytes();
    t_word32();
    t_hword16();
    t_reserved();
    t_lock();
    t_dma();
    t_disable();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule